// File: doc/BRIEF.md
# USB Device Event Interrupt Aggregator

This block collects single-cycle event pulses from a USB device controller into a 32-bit event status register. A matching enable register selects which events may raise the interrupt line. A second pair of registers tracks acknowledge and stall completions for 21 data endpoints, one bit per endpoint, with its own enable mask. That pair reaches the main status register through a derived summary bit, so one interrupt output covers all controller events.

Software reaches the four registers through a plain memory-mapped port. A write to the write port takes effect at the next clock edge. A read returns data in the same cycle, selected by byte offset. Status bits are sticky and are cleared by writing ones. Endpoint completions are serviced by reading the endpoint status register and clearing each set endpoint bit there. The summary bit then drops by itself.

The unit has no sequencing of its own. Its only state is four registers that update in a single cycle. The interrupt line is a combinational function of those registers.

Top module: `usb_evt_irq_unit`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: A high pulse on `dev_evt_i[k]` sets status bit k at the next clock edge, for k in 0..15 and 17. The positions are: 0 setup received, 1 control-OUT ack/stall, 2 control-OUT NAK, 3 control-IN ack/stall, 4 control-IN NAK, 5 hub-endpoint IN ack, 6 bus reset, 7 bus suspend, 8 suspend/resume change, 9..15 sub-device events, 17 endpoint NAK summary.
- R3: Writing a 1 to a status bit at offset 0x0C clears it. Writing a 0 leaves it unchanged.
- R4: When an event pulse and a write-one-to-clear reach the same bit in the same cycle, the bit stays set.
- R5: The endpoint status register at offset 0x18 holds bits 0..20. Bit n is set by a pulse on `ep_ack_evt_i[n]` and cleared by writing 1 to bit n.
- R6: Status bit 16 reads as the OR of (endpoint status AND endpoint enable). Writing bit 16 at 0x0C has no effect, and `dev_evt_i[16]` is ignored.
- R7: `irq_o` is high exactly when (status AND enable) is nonzero. This includes bit 16.
- R8: The enable register sits at offset 0x08 and holds bits 0..17. The endpoint enable register sits at offset 0x10 and holds bits 0..20. Both read back what was written.
- R9: Status bits 18..31, enable bits 18..31 and endpoint bits 21..31 always read zero. Writes to them are ignored.
- R10: Any offset other than 0x08, 0x0C, 0x10 and 0x18 reads zero, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr_i | input | 8 | Byte offset for reads and writes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| dev_evt_i | input | 18 | Controller event pulses, one per status position |
| ep_ack_evt_i | input | 21 | Per-endpoint ack/stall completion pulses |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that event inputs are clean synchronous levels sampled at each edge. They also assume that a write strobe held across several edges counts as several writes, so a clear held high keeps clearing unless an event re-sets the bit. The stimulus drives every pulse and strobe for exactly one clock period, starting from the falling edge. It never leaves an input unknown after reset. The same-cycle collision between an event and a clear is produced deliberately by raising both at one falling edge.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int DEV_EVTS = 18;
    localparam int EP_NUM   = 21;
    localparam int SUM_BIT  = 16;

    localparam logic [ADDR_W-1:0] OFS_ENABLE = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_EP_EN  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EP_STS = 8'h18;

    localparam logic [DATA_W-1:0] EN_MASK  = (DATA_W'(1) << DEV_EVTS) - 1;
    localparam logic [DATA_W-1:0] STS_MASK = EN_MASK & ~(DATA_W'(1) << SUM_BIT);
    localparam logic [DATA_W-1:0] EP_MASK  = (DATA_W'(1) << EP_NUM) - 1;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_STATUS,
        SEL_EP_EN,
        SEL_EP_STS
    } reg_sel_e;
endpackage

// File: rtl/w1c_bank.sv
module w1c_bank #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] sts_o
);
    logic [W-1:0] sts_q;
    logic [W-1:0] sts_d;

    always_comb begin
        sts_d = ((sts_q & ~clr_i) | set_i) & MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= sts_d;
    end

    assign sts_o = sts_q;

    // R3: a cleared bit with no competing event is low afterwards
    p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i)) |=> ((sts_q & $past(clr_i & ~set_i)) == '0));

    // R4: an event sets its bit even if a clear hits it in the same cycle
    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & MASK)) |=> ((sts_q & $past(set_i & MASK)) == $past(set_i & MASK)));

    // R3: no event and no clear, bank holds
    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(sts_q));
endmodule

// File: rtl/mask_reg.sv
module mask_reg #(
    parameter int           W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (we_i) q <= wdata_i & MASK;
    end

    assign q_o = q;

    // R8: a written value is visible after the edge
    p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (q == ($past(wdata_i) & MASK)));
endmodule

// File: rtl/usb_evt_irq_unit.sv
module usb_evt_irq_unit
    import usb_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic [DEV_EVTS-1:0] dev_evt_i,
    input  logic [EP_NUM-1:0] ep_ack_evt_i,
    output logic              irq_o
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] en_q, sts_q, ep_en_q, ep_sts_q, sts_view;
    logic [DATA_W-1:0] sts_clr, ep_clr;
    logic              ep_summary;

    always_comb begin
        unique case (bus_addr_i)
            OFS_ENABLE: sel = SEL_ENABLE;
            OFS_STATUS: sel = SEL_STATUS;
            OFS_EP_EN:  sel = SEL_EP_EN;
            OFS_EP_STS: sel = SEL_EP_STS;
            default:    sel = SEL_NONE;
        endcase
    end

    assign sts_clr = (bus_wr_i && sel == SEL_STATUS) ? bus_wdata_i : '0;
    assign ep_clr  = (bus_wr_i && sel == SEL_EP_STS) ? bus_wdata_i : '0;

    mask_reg #(.W(DATA_W), .MASK(EN_MASK)) u_en (
        .clk(clk), .rst_n(rst_n),
        .we_i(bus_wr_i && sel == SEL_ENABLE),
        .wdata_i(bus_wdata_i), .q_o(en_q));

    mask_reg #(.W(DATA_W), .MASK(EP_MASK)) u_ep_en (
        .clk(clk), .rst_n(rst_n),
        .we_i(bus_wr_i && sel == SEL_EP_EN),
        .wdata_i(bus_wdata_i), .q_o(ep_en_q));

    w1c_bank #(.W(DATA_W), .MASK(STS_MASK)) u_sts (
        .clk(clk), .rst_n(rst_n),
        .set_i(DATA_W'(dev_evt_i)), .clr_i(sts_clr), .sts_o(sts_q));

    w1c_bank #(.W(DATA_W), .MASK(EP_MASK)) u_ep_sts (
        .clk(clk), .rst_n(rst_n),
        .set_i(DATA_W'(ep_ack_evt_i)), .clr_i(ep_clr), .sts_o(ep_sts_q));

    assign ep_summary = |(ep_sts_q & ep_en_q);

    always_comb begin
        sts_view          = sts_q;
        sts_view[SUM_BIT] = ep_summary;
    end

    always_comb begin
        unique case (sel)
            SEL_ENABLE: bus_rdata_o = en_q;
            SEL_STATUS: bus_rdata_o = sts_view;
            SEL_EP_EN:  bus_rdata_o = ep_en_q;
            SEL_EP_STS: bus_rdata_o = ep_sts_q;
            default:    bus_rdata_o = '0;
        endcase
    end

    assign irq_o = |(sts_view & en_q);

    // R7: with every enable off the line stays low
    p_quiet_when_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq_o);

    // R6: the summary needs a pending endpoint bit
    p_summary_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ep_sts_q == '0) |-> !sts_view[SUM_BIT]);
endmodule

// File: tb/usb_evt_irq_unit_bench.sv
module usb_evt_irq_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic [17:0] dev_evt = '0;
    logic [20:0] ep_evt = '0;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    always #2 clk = ~clk;

    usb_evt_irq_unit u_usb_evt_irq_unit (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .bus_rdata_o(bus_rdata), .dev_evt_i(dev_evt), .ep_ack_evt_i(ep_evt),
        .irq_o(irq));

    // monitor: compares queued expectations in the low clock phase
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? {31'h0, irq} : bus_rdata;
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        sb_q.push_back('{1'b0, e, tag});
    endtask

    task automatic expect_irq(input logic e, input string tag);
        @(negedge clk);
        sb_q.push_back('{1'b1, {31'h0, e}, tag});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic pulse(input logic [17:0] d, input logic [20:0] e);
        @(negedge clk);
        dev_evt = d; ep_evt = e;
        @(negedge clk);
        dev_evt = '0; ep_evt = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_rd(8'h08, 32'h0, "R1 enable");
        expect_rd(8'h0C, 32'h0, "R1 status");
        expect_rd(8'h10, 32'h0, "R1 ep enable");
        expect_rd(8'h18, 32'h0, "R1 ep status");
        expect_irq(1'b0, "R1 irq");

        // R2 event positions 0, 6, 9, 17
        pulse(18'h20241, '0);
        expect_rd(8'h0C, 32'h0002_0241, "R2 set bits");
        expect_irq(1'b0, "R7 masked");

        // R3 clear bit 6, zeros elsewhere
        wr(8'h0C, 32'h0000_0040);
        expect_rd(8'h0C, 32'h0002_0201, "R3 w1c");
        wr(8'h0C, 32'h0);
        expect_rd(8'h0C, 32'h0002_0201, "R3 write zero");

        // R4 collision on bit 0
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h0C; bus_wdata = 32'h1; dev_evt = 18'h1;
        @(negedge clk);
        bus_wr = 1'b0; dev_evt = '0;
        expect_rd(8'h0C, 32'h0002_0201, "R4 event wins");

        // R8 / R9 enable readback
        wr(8'h08, 32'hFFFF_FFFF);
        expect_rd(8'h08, 32'h0003_FFFF, "R8 R9 enable");
        expect_irq(1'b1, "R7 enabled");
        wr(8'h0C, 32'hFFFF_FFFF);
        expect_rd(8'h0C, 32'h0, "R3 R9 clear all");
        expect_irq(1'b0, "R7 nothing pending");

        // R5 endpoint bits 3 and 20
        pulse(18'h10000, 21'h10_0008);
        expect_rd(8'h18, 32'h0010_0008, "R5 ep set");
        expect_rd(8'h0C, 32'h0, "R6 summary needs enable, evt16 ignored");
        wr(8'h10, 32'hFFFF_FFFF);
        expect_rd(8'h10, 32'h001F_FFFF, "R8 R9 ep enable");
        wr(8'h10, 32'h0000_0008);
        expect_rd(8'h0C, 32'h0001_0000, "R6 summary set");
        expect_irq(1'b1, "R7 via summary");
        wr(8'h0C, 32'h0001_0000);
        expect_rd(8'h0C, 32'h0001_0000, "R6 bit16 write ignored");
        wr(8'h18, 32'h0000_0008);
        expect_rd(8'h18, 32'h0010_0000, "R5 ep w1c");
        expect_rd(8'h0C, 32'h0, "R6 summary drops");
        expect_irq(1'b0, "R7 low after service");

        // R10 unmapped offsets
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        expect_rd(8'h04, 32'h0, "R10 unmapped read");
        expect_rd(8'h08, 32'h0003_FFFF, "R10 enable kept");
        expect_rd(8'h10, 32'h0000_0008, "R10 ep enable kept");
        expect_rd(8'h18, 32'h0010_0000, "R10 ep status kept");

        // R7 only the selected source raises the line
        wr(8'h08, 32'h0000_0080);
        pulse(18'h00100, '0);
        expect_irq(1'b0, "R7 other source");
        pulse(18'h00080, '0);
        expect_irq(1'b1, "R7 suspend source");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule